// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block turns the bus clock into the serial clock of an SPI controller. It also produces two single-cycle strobes that tell a separate shift engine when to sample incoming data and when to launch outgoing data. A law-select bit chooses how the divider value is read. Under the power-of-two law, the low four bits give an exponent. Under the linear law, the whole eight-bit field gives an even divide ratio.

Divider, law, polarity and phase are captured into shadow registers only while the run enable is low. Changing them during a run therefore cannot disturb a frame in progress. When the run enable goes high, the half-period counter starts from zero. The first serial clock transition therefore comes only after a complete half-period. While idle, the serial clock rests at the level of the polarity input.

Top module: `spi_sclk_divgen`

## Requirements
- R1: While reset is asserted, `sclk` is low and both `smp_stb` and `lch_stb` are low, whatever the polarity input.
- R2: While `run_en` is low, `sclk` takes the value of `cpol` from the next rising bus clock edge onward, and neither strobe is ever asserted.
- R3: With `law_sel` = 0, only `div_val[3:0]` (value N, 0 to 15) is used and the upper bits are ignored. `sclk` changes level every 2^N bus cycles, for a divide ratio of 2^(N+1).
- R4: With `law_sel` = 1, all of `div_val` (value N, 0 to 255) is used. `sclk` changes level every N+1 bus cycles, for a divide ratio of 2*(N+1).
- R5: After `run_en` rises, the first `sclk` transition happens on the H-th rising bus clock edge at which `run_en` is sampled high, where H is the half-period of R3 or R4.
- R6: Changes to `law_sel`, `div_val` or `cpha` while `run_en` is high have no effect. They take effect only after `run_en` has been low for at least one rising edge.
- R7: With phase 0, `smp_stb` pulses when `sclk` leaves its idle level (the leading edge), and `lch_stb` pulses when it returns to idle (the trailing edge).
- R8: With phase 1, `lch_stb` pulses on the leading edge and `smp_stb` pulses on the trailing edge.
- R9: Each strobe lasts exactly the one bus cycle in which `sclk` first shows its new level. The two strobes are never high together, and neither is high in a cycle where `sclk` did not just change.
- R10: N = 0 under either law makes `sclk` change on every running bus clock edge, which is half the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; settings are captured while low |
| law_sel | input | 1 | 0 = power-of-two law, 1 = linear law |
| div_val | input | DIV_W | Divider field N |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk | output | 1 | Serial clock |
| smp_stb | output | 1 | One-cycle sample strobe for the shift engine |
| lch_stb | output | 1 | One-cycle launch strobe for the shift engine |

## Verification
The assertions assume that reset is held for at least one rising edge. They also assume that the settings seen during a run are the ones captured at the last disabled edge, so the leading-edge direction checks compare `sclk` against the shadowed polarity. The stimulus changes inputs only on falling edges. It keeps `run_en` low for several cycles before each run, so the shadow registers and the idle level have settled. The mid-run settings change is made on a falling edge, well after the run started. This exercises the hold behaviour without landing on the capturing edge.

// File: rtl/sckd_pkg.sv
package sckd_pkg;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } law_e;

    typedef struct packed {
        law_e law;
        logic cpol;
        logic cpha;
    } mode_t;

endpackage

// File: rtl/sckd_cfg_hold.sv
module sckd_cfg_hold
    import sckd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  law_e             law_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             cpol_in,
    input  logic             cpha_in,
    output mode_t            mode_q,
    output logic [DIV_W-1:0] div_q
);

    typedef struct packed {
        mode_t            mode;
        logic [DIV_W-1:0] div;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!run_en) begin
            h_d.mode.law  = law_in;
            h_d.mode.cpol = cpol_in;
            h_d.mode.cpha = cpha_in;
            h_d.div       = div_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign mode_q = h_q.mode;
    assign div_q  = h_q.div;

    // R6: shadow settings frozen across any edge where the run enable is high
    a_r6_hold_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(h_q));

endmodule

// File: rtl/sckd_half_calc.sv
module sckd_half_calc
    import sckd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int EXP_W = 4,
    parameter int TC_W  = 15
) (
    input  law_e             law,
    input  logic [DIV_W-1:0] div,
    output logic [TC_W-1:0]  tc
);

    logic [TC_W:0]   pow_full;
    logic [TC_W:0]   pow_less;
    logic [TC_W-1:0] tc_pow;
    logic [TC_W-1:0] tc_lin;

    always_comb begin
        pow_full = {{TC_W{1'b0}}, 1'b1} << div[EXP_W-1:0];
        pow_less = pow_full - {{TC_W{1'b0}}, 1'b1};
        tc_pow   = pow_less[TC_W-1:0];
    end

    generate
        if (TC_W > DIV_W) begin : g_lin_pad
            assign tc_lin = {{(TC_W-DIV_W){1'b0}}, div};
        end else begin : g_lin_fit
            assign tc_lin = div[TC_W-1:0];
        end
    endgenerate

    assign tc = (law == LAW_LINEAR) ? tc_lin : tc_pow;

endmodule

// File: rtl/sckd_edge_gen.sv
module sckd_edge_gen
    import sckd_pkg::*;
#(
    parameter int TC_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            idle_pol,
    input  mode_t           mode,
    input  logic [TC_W-1:0] tc,
    output logic            sclk,
    output logic            smp_stb,
    output logic            lch_stb
);

    typedef struct packed {
        logic [TC_W-1:0] cnt;
        logic            sclk;
        logic            smp;
        logic            lch;
    } gen_t;

    gen_t g_d, g_q;
    logic leading;

    always_comb begin
        g_d     = g_q;
        g_d.smp = 1'b0;
        g_d.lch = 1'b0;
        leading = (g_q.sclk == mode.cpol);
        if (!run_en) begin
            g_d.cnt  = '0;
            g_d.sclk = idle_pol;
        end else if (g_q.cnt == tc) begin
            g_d.cnt  = '0;
            g_d.sclk = ~g_q.sclk;
            g_d.smp  = mode.cpha ? !leading : leading;
            g_d.lch  = mode.cpha ? leading : !leading;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk    = g_q.sclk;
    assign smp_stb = g_q.smp;
    assign lch_stb = g_q.lch;

    // R9: never both strobes at once
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(g_q.smp && g_q.lch));

    // R9: a strobe only in a cycle where the serial clock just moved
    a_r9_strobe_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.smp || g_q.lch) |-> (g_q.sclk != $past(g_q.sclk)));

    // R2: a disabled edge leaves both strobes low
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!g_q.smp && !g_q.lch));

    // R5: counter never passes the terminal count
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= tc);

    // R7: phase 0 samples as the clock leaves idle
    a_r7_lead_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.smp && !mode.cpha) |-> (g_q.sclk != mode.cpol));

    // R8: phase 1 samples as the clock returns to idle
    a_r8_trail_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.smp && mode.cpha) |-> (g_q.sclk == mode.cpol));

endmodule

// File: rtl/spi_sclk_divgen.sv
module spi_sclk_divgen
    import sckd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             law_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             cpol,
    input  logic             cpha,
    output logic             sclk,
    output logic             smp_stb,
    output logic             lch_stb
);

    localparam int POW_TC_W = (1 << EXP_W) - 1;
    localparam int TC_W     = (POW_TC_W > DIV_W) ? POW_TC_W : DIV_W;

    mode_t           mode_sh;
    logic [DIV_W-1:0] div_sh;
    logic [TC_W-1:0]  tc;

    sckd_cfg_hold #(.DIV_W(DIV_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .law_in  (law_e'(law_sel)),
        .div_in  (div_val),
        .cpol_in (cpol),
        .cpha_in (cpha),
        .mode_q  (mode_sh),
        .div_q   (div_sh)
    );

    sckd_half_calc #(.DIV_W(DIV_W), .EXP_W(EXP_W), .TC_W(TC_W)) u_calc (
        .law (mode_sh.law),
        .div (div_sh),
        .tc  (tc)
    );

    sckd_edge_gen #(.TC_W(TC_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .idle_pol (cpol),
        .mode     (mode_sh),
        .tc       (tc),
        .sclk     (sclk),
        .smp_stb  (smp_stb),
        .lch_stb  (lch_stb)
    );

endmodule

// File: tb/sim_spi_sclk_divgen.sv
module sim_spi_sclk_divgen;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {law, cpol, cpha, div[7:0], expected half-period[16:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'd0,   17'd1},
        {1'b0, 1'b1, 1'b0, 8'd3,   17'd8},
        {1'b1, 1'b0, 1'b1, 8'd0,   17'd1},
        {1'b1, 1'b1, 1'b1, 8'd5,   17'd6},
        {1'b1, 1'b0, 1'b0, 8'd255, 17'd256},
        {1'b0, 1'b0, 1'b1, 8'h1A,  17'd1024},
        {1'b1, 1'b1, 1'b0, 8'd1,   17'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic law_sel = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic cpol = 1'b1;
    logic cpha = 1'b0;
    logic sclk, smp_stb, lch_stb;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sclk_divgen u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .law_sel(law_sel),
        .div_val(div_val), .cpol(cpol), .cpha(cpha),
        .sclk(sclk), .smp_stb(smp_stb), .lch_stb(lch_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic l, input logic [7:0] d, input logic p, input logic h);
        @(negedge clk);
        run_en = 1'b0; law_sel = l; div_val = d; cpol = p; cpha = h;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_toggle(input logic from_lvl, output int cnt, output int noise);
        cnt = 0;
        noise = 0;
        do begin
            @(posedge clk);
            #1;
            cnt++;
            if (sclk == from_lvl && (smp_stb || lch_stb)) noise++;
        end while (sclk == from_lvl && cnt < 70000);
    endtask

    task automatic run_case(input logic l, input logic [7:0] d, input logic p,
                            input logic h, input int half);
        int c1, c2, c3, z1, z2, z3;
        string rq;
        rq = l ? "R4" : "R3";
        setup(l, d, p, h);
        chk(sclk == p && !smp_stb && !lch_stb, "R2 idle level", int'(sclk), int'(p));
        @(negedge clk);
        run_en = 1'b1;
        wait_toggle(p, c1, z1);
        chk(c1 == half, {rq, "/R5 first half-period"}, c1, half);
        chk(smp_stb == !h && lch_stb == h, h ? "R8 leading strobes" : "R7 leading strobes",
            int'({smp_stb, lch_stb}), int'({!h, h}));
        wait_toggle(!p, c2, z2);
        chk(c2 == half, {rq, " second half-period"}, c2, half);
        chk(smp_stb == h && lch_stb == !h, h ? "R8 trailing strobes" : "R7 trailing strobes",
            int'({smp_stb, lch_stb}), int'({h, !h}));
        wait_toggle(p, c3, z3);
        chk(c3 == half, {rq, " third half-period"}, c3, half);
        chk(z1 + z2 + z3 == 0, "R9 strobes only on transitions", z1 + z2 + z3, 0);
        if (half == 1) chk(c1 + c2 == 2, "R10 full period two bus cycles", c1 + c2, 2);
        @(negedge clk);
        run_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c, z;
        // R1: reset state with polarity input high
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0 && !smp_stb && !lch_stb, "R1 reset outputs", int'({sclk, smp_stb, lch_stb}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1 && !smp_stb && !lch_stb, "R2 idle follows polarity", int'(sclk), 1);

        for (int i = 0; i < NVEC; i++) begin
            run_case(VEC[i][27], VEC[i][24:17], VEC[i][26], VEC[i][25], int'(VEC[i][16:0]));
        end

        // R6: settings changed mid-run are ignored until the next disabled edge
        setup(1'b1, 8'd3, 1'b0, 1'b0);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        law_sel = 1'b0; div_val = 8'd9; cpha = 1'b1;
        wait_toggle(1'b0, c, z);
        chk(c == 2, "R6 remaining half-period unchanged", c, 2);
        chk(smp_stb == 1'b1 && lch_stb == 1'b0, "R6 phase change ignored",
            int'({smp_stb, lch_stb}), 2);
        wait_toggle(1'b1, c, z);
        chk(c == 4, "R6 next half-period unchanged", c, 4);
        @(negedge clk);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        wait_toggle(1'b0, c, z);
        chk(c == 512, "R6 new settings after re-enable", c, 512);
        chk(smp_stb == 1'b0 && lch_stb == 1'b1, "R6 new phase after re-enable",
            int'({smp_stb, lch_stb}), 1);
        @(negedge clk);
        run_en = 1'b0;

        // R3: largest exponent
        setup(1'b0, 8'd15, 1'b1, 1'b0);
        chk(sclk == 1'b1 && !smp_stb && !lch_stb, "R2 idle high", int'(sclk), 1);
        @(negedge clk);
        run_en = 1'b1;
        wait_toggle(1'b1, c, z);
        chk(c == 32768, "R3 exponent 15 half-period", c, 32768);
        chk(z == 0, "R9 no strobe while counting", z, 0);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk(!smp_stb && !lch_stb && sclk == 1'b1, "R2 quiet after disable",
            int'({sclk, smp_stb, lch_stb}), 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule